// File: doc/BRIEF.md
# SPI Master Shift Engine with Write-Collision Flag

The block is the master side of a Serial Peripheral Interface link, reached through a small register port. Software first programs the control register: an enable bit, the idle level of the serial clock, and the sampling phase. It then writes a byte to the data register, which starts an 8-bit full-duplex exchange. The byte is shifted out most significant bit first. At the same time the byte returned by the slave is shifted in. After the exchange, the returned byte is read back from the same data address.

Bit timing comes from an external single-cycle baud tick input. The serial clock changes level once on each tick, so one tick is one half-period. A whole byte takes 16 ticks. The baud source is expected to space its ticks at least three system clocks apart. Slave select is driven by a general-purpose pin outside this block.

If software writes the data register while an exchange is still running, the new byte is discarded, the exchange continues untouched, and a write-collision flag is raised in the status register. That flag is cleared only by reading the status register while the flag is set.

Top module: `spiCollMaster`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, and both the serial clock and the serial data output are 0.
- R2: When enable is 1 and no exchange is running, a write to address 0 starts an exchange. On the next cycle, status bit 0 (busy) is 1, status bit 7 (complete) is 0, and the serial data output carries bit 7 of the written byte.
- R3: While busy, the serial clock changes level exactly once on each baud tick, 16 times per byte. When idle, it rests at the level of control bit 1 (polarity).
- R4: Edges are numbered from 0 at the start of an exchange. With control bit 2 (phase) at 0, the serial data input is captured on even-numbered edges and the output changes on odd-numbered edges. With phase at 1, the roles of even and odd edges swap. Data goes out most significant bit first.
- R5: One cycle after the 16th tick, busy is 0 and complete (status bit 7) is 1. Reading address 0 then returns the 8 captured bits, the first captured bit in bit 7. Complete returns to 0 when the next exchange starts.
- R6: A write to address 0 while busy sets status bit 5 (collision). The written byte is discarded, and the bits sent and received by the running exchange are unchanged.
- R7: A read of address 1 while collision is 1 returns collision as 1 and clears it on the following cycle. No other action clears it.
- R8: When enable (control bit 0) is 0, writes to address 0 start nothing and leave the data register unchanged, and baud ticks are ignored. Clearing enable during an exchange ends it: busy drops, the serial clock returns to its idle level, and complete stays 0.
- R9: Register map: address 0 is data, address 1 is status (bits 7, 5 and 0 as above, all other bits 0), address 2 is control (bits 2..0 as above, all other bits 0), and address 3 reads 0. Read data is valid in the same cycle as the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (drives the read side effect) |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data, combinational from addr |
| baudTick | input | 1 | Single-cycle half-bit tick from the baud generator |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Register writes take effect at the rising edge on which they are sampled, and read data is combinational, so a status value is due in the cycle after the access that changed it. The serial clock and the serial data output move in the cycle after the tick edge. Complete and the received byte appear one cycle after the 16th tick. The bench drives and reads the register port around the falling edge. Its pin monitor samples 2 ns after each rising edge, acting as the slave and comparing the captured transmit stream against a queue of expected bytes. Each slave bit is presented at least one tick before the edge that captures it.

// File: rtl/spiMstPkg.sv
package spiMstPkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_WCOL_BIT = 5;
  localparam int STAT_BUSY_BIT = 0;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_CPOL_BIT = 1;
  localparam int CTRL_CPHA_BIT = 2;
  localparam int CTRL_W        = 3;

  // Strobes from control to datapath, one cycle each except busy.
  typedef struct packed {
    logic load;      // accept new byte into the shifter
    logic sample;    // capture serial input
    logic launch;    // present next serial output bit
    logic toggle;    // flip the serial clock phase
    logic clrPhase;  // force clock phase to idle
    logic busy;      // exchange in progress (level)
  } spiStrobeT;
endpackage

// File: rtl/spiMstCtrl.sv
module spiMstCtrl
  import spiMstPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CTRL_W-1:0] ctrlIn,
  input  logic              baudTick,
  output spiStrobeT         strb,
  output logic              enable,
  output logic              cpol,
  output logic              cpha,
  output logic              wcol,
  output logic              done,
  output logic              busy
);
  localparam int EDGES = 2 * DATA_W;
  localparam int CNT_W = $clog2(EDGES);
  localparam logic [CNT_W-1:0] LAST_EDGE = CNT_W'(EDGES - 1);

  logic [CNT_W-1:0] edgeCnt;
  logic dataWr, ctrlWr, statRd;
  logic startOk, collide, stepEn, lastEdge, abortNow;

  assign dataWr   = wrEn && (addr == ADDR_DATA);
  assign ctrlWr   = wrEn && (addr == ADDR_CTRL);
  assign statRd   = rdEn && (addr == ADDR_STAT);
  assign startOk  = dataWr && enable && !busy;
  assign collide  = dataWr && busy;
  assign stepEn   = busy && enable && baudTick;
  assign lastEdge = (edgeCnt == LAST_EDGE);
  assign abortNow = busy && !enable;

  always_comb begin
    strb.load     = startOk;
    strb.sample   = stepEn && (edgeCnt[0] == cpha);
    strb.launch   = stepEn && (edgeCnt[0] != cpha);
    strb.toggle   = stepEn;
    strb.clrPhase = startOk || abortNow;
    strb.busy     = busy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable <= 1'b0;
      cpol   <= 1'b0;
      cpha   <= 1'b0;
    end else if (ctrlWr) begin
      enable <= ctrlIn[CTRL_EN_BIT];
      cpol   <= ctrlIn[CTRL_CPOL_BIT];
      cpha   <= ctrlIn[CTRL_CPHA_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      edgeCnt <= '0;
      done    <= 1'b0;
    end else if (startOk) begin
      busy    <= 1'b1;
      edgeCnt <= '0;
      done    <= 1'b0;
    end else if (abortNow) begin
      busy    <= 1'b0;
    end else if (stepEn) begin
      edgeCnt <= edgeCnt + 1'b1;
      if (lastEdge) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wcol <= 1'b0;
    else if (collide)       wcol <= 1'b1;
    else if (statRd && wcol) wcol <= 1'b0;
  end

  AST_WCOL_ON_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && busy) |=> wcol); // R6
  AST_WCOL_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (statRd && wcol) |=> !wcol); // R7
  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> (busy && !done)); // R2
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (stepEn && lastEdge) |=> (!busy && done)); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !busy); // R8
endmodule

// File: rtl/spiMstData.sv
module spiMstData
  import spiMstPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobeT         strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cpol,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [DATA_W-1:0] shReg
);
  logic phase;
  logic mosiBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shReg <= '0;
    else if (strb.load)   shReg <= wrData;
    else if (strb.sample) shReg <= {shReg[DATA_W-2:0], miso};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            mosiBit <= 1'b0;
    else if (strb.load)   mosiBit <= wrData[DATA_W-1];
    else if (strb.launch) mosiBit <= shReg[DATA_W-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              phase <= 1'b0;
    else if (strb.clrPhase) phase <= 1'b0;
    else if (strb.toggle)   phase <= ~phase;
  end

  assign sclk = cpol ^ phase;
  assign mosi = mosiBit;

  AST_SCLK_IDLE_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.busy |-> !phase); // R3
  AST_SAMPLE_LAUNCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sample, strb.launch, strb.load})); // R4
endmodule

// File: rtl/spiCollMaster.sv
module spiCollMaster
  import spiMstPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              baudTick,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  spiStrobeT strb;
  logic enable, cpol, cpha, wcol, done, busy;
  logic [DATA_W-1:0] shReg;

  spiMstCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .ctrlIn(wrData[CTRL_W-1:0]), .baudTick(baudTick), .strb(strb),
    .enable(enable), .cpol(cpol), .cpha(cpha), .wcol(wcol),
    .done(done), .busy(busy)
  );

  spiMstData #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .cpol(cpol),
    .miso(miso), .sclk(sclk), .mosi(mosi), .shReg(shReg)
  );

  always_comb begin
    rdData = '0;
    unique case (addr)
      ADDR_DATA: rdData = shReg;
      ADDR_STAT: begin
        rdData[STAT_DONE_BIT] = done;
        rdData[STAT_WCOL_BIT] = wcol;
        rdData[STAT_BUSY_BIT] = busy;
      end
      ADDR_CTRL: begin
        rdData[CTRL_EN_BIT]   = enable;
        rdData[CTRL_CPOL_BIT] = cpol;
        rdData[CTRL_CPHA_BIT] = cpha;
      end
      default: rdData = '0;
    endcase
  end
endmodule

// File: tb/sim_spiCollMaster.sv
module sim_spiCollMaster;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic baudTick = 1'b0;
  logic sclk, mosi;
  logic miso = 1'b0;

  int checks = 0, failures = 0;
  bit tickOn = 1'b0;
  int tickCnt = 0;

  // scoreboard / monitor state
  logic [7:0] expQ[$];
  int armSeq = 0, seenSeq = 0;
  int curCpha = 0;
  logic [7:0] slvByte = '0;
  int monEdges = 0;
  int bitPtr = 0;
  bit monActive = 1'b0;
  logic [7:0] gotTx = '0;
  logic prevSclk = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spiCollMaster u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .baudTick(baudTick),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // baud ticks every 4 cycles
  initial forever begin
    @(negedge clk);
    tickCnt++;
    baudTick = tickOn && (tickCnt % 4 == 0);
  end

  // pin monitor acting as slave; pops expected transmit bytes
  initial forever begin
    @(posedge clk);
    #2;
    if (armSeq != seenSeq) begin
      seenSeq = armSeq;
      monEdges = 0;
      gotTx = '0;
      monActive = 1'b1;
      if (curCpha == 0) begin miso = slvByte[7]; bitPtr = 6; end
      else bitPtr = 7;
    end else if (monActive && sclk != prevSclk) begin
      if ((monEdges % 2) == curCpha) gotTx = {gotTx[6:0], mosi};
      else if (bitPtr >= 0) begin miso = slvByte[bitPtr]; bitPtr--; end
      monEdges++;
      if (monEdges == 16) begin
        logic [7:0] e;
        monActive = 1'b0;
        e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
        check(gotTx === e, "R4/R6 serial out MSB first", gotTx, e);
      end
    end
    prevSclk = sclk;
  end

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 400; i++) begin
      busRead(2'd1, s);
      if (!s[0]) break;
    end
  endtask

  task automatic doXfer(input logic [7:0] tx, input logic [7:0] slv,
                        input bit pol, input bit pha, input bit collide);
    logic [7:0] s, d;
    busWrite(2'd2, {5'b0, pha, pol, 1'b1});
    @(negedge clk);
    check(sclk == pol, "R3 idle clock level", sclk, pol);
    curCpha = pha;
    slvByte = slv;
    expQ.push_back(tx);
    armSeq++;
    busWrite(2'd0, tx);
    check(mosi == tx[7], "R2 first bit on mosi", mosi, tx[7]);
    busRead(2'd1, s);
    check(s[0] == 1'b1 && s[7] == 1'b0, "R2 busy set complete clear", s, 8'h01);
    if (collide) begin
      busWrite(2'd0, ~tx);
      busRead(2'd1, s);
      check(s[5] == 1'b1, "R6 collision flag set", s[5], 1);
      busRead(2'd1, s);
      check(s[5] == 1'b0, "R7 collision cleared by status read", s[5], 0);
    end
    waitIdle();
    busRead(2'd1, s);
    check(s == 8'h80, "R5 complete after 16 ticks", s, 8'h80);
    busRead(2'd0, d);
    check(d == slv, "R5 received byte", d, slv);
    check(monEdges == 16, "R3 sixteen clock edges", monEdges, 16);
    check(sclk == pol, "R3 clock back to idle", sclk, pol);
  endtask

  initial begin
    #(8 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    busRead(2'd1, r); check(r == 8'h00, "R1 status after reset", r, 0);
    busRead(2'd2, r); check(r == 8'h00, "R1 control after reset", r, 0);
    check(sclk == 1'b0 && mosi == 1'b0, "R1 serial pins after reset", {sclk, mosi}, 0);
    busRead(2'd3, r); check(r == 8'h00, "R9 unused address", r, 0);

    // disabled: write ignored, ticks ignored
    tickOn = 1'b1;
    busWrite(2'd0, 8'h3C);
    repeat (20) @(negedge clk);
    busRead(2'd1, r); check(r == 8'h00, "R8 disabled write starts nothing", r, 0);
    busRead(2'd0, r); check(r == 8'h00, "R8 data unchanged when disabled", r, 0);
    check(sclk == 1'b0, "R8 ticks ignored when disabled", sclk, 0);

    busWrite(2'd2, 8'hFF);
    busRead(2'd2, r); check(r == 8'h07, "R9 control readback", r, 8'h07);

    doXfer(8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0);
    doXfer(8'h5A, 8'hC3, 1'b1, 1'b1, 1'b0);
    doXfer(8'h81, 8'h7E, 1'b1, 1'b0, 1'b0);
    doXfer(8'h00, 8'hFF, 1'b0, 1'b1, 1'b0);
    doXfer(8'h96, 8'h69, 1'b0, 1'b0, 1'b1);
    doXfer(8'hF0, 8'h0F, 1'b1, 1'b1, 1'b1);

    // abort by clearing enable mid-exchange
    busWrite(2'd2, 8'h03);
    slvByte = 8'h55; curCpha = 0;
    armSeq++;
    busWrite(2'd0, 8'hCC);
    repeat (10) @(negedge clk);
    busWrite(2'd2, 8'h02);
    busRead(2'd1, r); check(r == 8'h00, "R8 abort drops busy, complete stays 0", r, 0);
    check(sclk == 1'b1, "R8 clock idle after abort", sclk, 1);
    repeat (20) @(negedge clk);
    check(sclk == 1'b1, "R8 ticks ignored after abort", sclk, 1);

    tickOn = 1'b0;
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule